// File: doc/BRIEF.md
# Scatter-Gather DMA Request Engine

This block takes DMA requests from a host and runs them one after another. Each request moves one packet between host memory and the on-board packet memory. A gather request reads up to four host fragments in order, for example a header buffer followed by several pages that are not next to each other. It writes them back to back into one packet region. A scatter request does the reverse: it reads one contiguous packet region and hands it out across the listed host fragments. Lengths and addresses count in 32-bit words, and a 4 KB host page is 1024 words.

Requests wait in an eight-entry queue. When each request finishes, a response word goes into a second eight-entry queue. Each request can opt in to a host interrupt. The host can therefore flag only the last packet of a large write and take a single interrupt for all of them. Host traffic goes out as burst commands on a simple request/acknowledge interface, followed by word-wide data beats.

The controller is one state machine:

| State | Purpose |
|---|---|
| IDLE | Waits for a queued request. |
| CHECK | Validates the fragment list and loads fragment 0. |
| CMD | Presents a burst command to the host. |
| DATA | Moves the beats of that burst. |
| NEXT | Advances to the next fragment. |
| DONE | Pushes the response and retires the request. |

Its transitions:

- IDLE→CHECK when the request queue is non-empty.
- CHECK→DONE on a malformed request, or CHECK→CMD otherwise.
- CMD→DATA on acknowledge.
- DATA→CMD when a burst ends but the fragment still has words left.
- DATA→NEXT when the fragment is exhausted.
- NEXT→CMD when more fragments remain, or NEXT→DONE after the last one.
- DONE→IDLE once the response queue has room.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the request queue reports empty and not full, no response is valid, the interrupt is low and no burst command is presented.
- R2: The request queue holds 8 requests, counting the one in progress, which leaves the queue only when its response is written. `req_ready` is the inverse of `q_full`, and `q_empty` is high when no request is held.
- R3: A gather request (`req_dir`=0) reads its fragments in list order and writes their words to consecutive packet memory words, starting at `req_pkt_addr`.
- R4: A scatter request (`req_dir`=1) reads consecutive packet memory words from `req_pkt_addr` and writes them to its fragments in list order.
- R5: Every burst command has between 1 and 16 beats and never crosses a 1024-word host page. Each burst covers the smallest of three amounts: the words left in the fragment, 16, and the words to the page end.
- R6: A burst command keeps `hb_addr`, `hb_beats` and `hb_we` unchanged until `hb_ack`.
- R7: Responses come back in issue order. `resp_data` carries the error flag in its top bit and the 4-bit request tag below it.
- R8: A request is an error when its fragment count is 0 or above 4, or when any used fragment has length 0 or length above 1024 words. An error request gives error flag 1 and issues no burst. Fragment slots beyond the count are ignored, and a length of exactly 1024 is valid.
- R9: Completing a request with `req_irq` set drives `irq` high from the next cycle on. Completing one with `req_irq` clear leaves `irq` unchanged. `irq` stays high until a `resp_pop` and is low in the cycle after the pop.
- R10: While the response queue holds 8 unread words, the engine stops in DONE and loses no completion. The request queue keeps filling behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Request queue can accept |
| req_tag | input | 4 | Request tag returned in the response |
| req_dir | input | 1 | 0 gather into packet memory, 1 scatter to host |
| req_irq | input | 1 | Raise interrupt on completion |
| req_nfrag | input | 3 | Number of fragments used |
| req_pkt_addr | input | 12 | Packet memory start word |
| req_frag_addr | input | 80 | Four 20-bit host word addresses, fragment 0 in the low bits |
| req_frag_len | input | 48 | Four 12-bit lengths in words, fragment 0 in the low bits |
| q_full | output | 1 | Request queue full |
| q_empty | output | 1 | Request queue empty |
| resp_valid | output | 1 | Response word available |
| resp_data | output | 5 | {error, tag} |
| resp_pop | input | 1 | Consume the response word |
| irq | output | 1 | Level interrupt |
| hb_req | output | 1 | Burst command valid |
| hb_we | output | 1 | Burst is a host write |
| hb_addr | output | 20 | Burst start host word address |
| hb_beats | output | 5 | Burst length in beats |
| hb_ack | input | 1 | Command accepted |
| hb_rvalid | input | 1 | Read data beat |
| hb_rdata | input | 32 | Read data |
| hb_wvalid | output | 1 | Write data beat offered |
| hb_wready | input | 1 | Write beat accepted |
| hb_wdata | output | 32 | Write data |
| pm_we | output | 1 | Packet memory write |
| pm_waddr | output | 12 | Packet memory write address |
| pm_wdata | output | 32 | Packet memory write data |
| pm_raddr | output | 12 | Packet memory read address |
| pm_rdata | input | 32 | Packet memory read data, same-cycle |

## Verification
The hardest state to reach is the one where the response queue is full and the engine is parked in DONE while the request queue has also filled. That state needs many completions with no host reads in between. The stimulus pushes sixteen short gather requests from a background process and withholds every pop. It then checks the full flags and the interrupt before draining all sixteen in order. Page splitting is exercised by fragments that start a few words before a 4 KB boundary, and by a maximum-length 1024-word fragment that runs as 64 bursts. The host model delays every acknowledge and inserts gaps between data beats.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_CMD,
        S_DATA,
        S_NEXT,
        S_DONE
    } sg_state_t;

    typedef enum logic {
        DIR_GATHER  = 1'b0,
        DIR_SCATTER = 1'b1
    } sg_dir_t;

endpackage

// File: rtl/sgdma_fifo.sv
module sgdma_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    assign rd_data = mem[rp];
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);

    // R2 / R10: the owner never writes into a full queue
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R2: retiring only ever happens with something held
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    // R2: a lone write grows the occupancy by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> !empty);

endmodule

// File: rtl/sgdma_burst_calc.sv
module sgdma_burst_calc #(
    parameter int HA_W       = 20,
    parameter int LEN_W      = 12,
    parameter int BEAT_W     = 5,
    parameter int MAX_BURST  = 16,
    parameter int PAGE_WORDS = 1024
) (
    input  logic [HA_W-1:0]   addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [BEAT_W-1:0] beats
);
    localparam int PG_W = $clog2(PAGE_WORDS);

    logic [31:0] to_end;
    logic [31:0] rem;
    logic [31:0] pick;

    always_comb begin
        to_end = 32'(PAGE_WORDS) - 32'(addr[PG_W-1:0]);
        rem    = 32'(remain);
        pick   = 32'(MAX_BURST);
        if (rem < pick)    pick = rem;
        if (to_end < pick) pick = to_end;
        beats  = BEAT_W'(pick);
    end

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int TAG_W          = 4,
    parameter int HA_W           = 20,
    parameter int PA_W           = 12,
    parameter int LEN_W          = 12,
    parameter int DATA_W         = 32,
    parameter int NFRAG          = 4,
    parameter int QDEPTH         = 8,
    parameter int MAX_BURST      = 16,
    parameter int PAGE_WORDS     = 1024,
    parameter int MAX_FRAG_WORDS = 1024,
    parameter int NF_W           = $clog2(NFRAG + 1),
    parameter int BEAT_W         = $clog2(MAX_BURST + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic                   req_dir,
    input  logic                   req_irq,
    input  logic [NF_W-1:0]        req_nfrag,
    input  logic [PA_W-1:0]        req_pkt_addr,
    input  logic [NFRAG*HA_W-1:0]  req_frag_addr,
    input  logic [NFRAG*LEN_W-1:0] req_frag_len,
    output logic                   q_full,
    output logic                   q_empty,
    output logic                   resp_valid,
    output logic [TAG_W:0]         resp_data,
    input  logic                   resp_pop,
    output logic                   irq,
    output logic                   hb_req,
    output logic                   hb_we,
    output logic [HA_W-1:0]        hb_addr,
    output logic [BEAT_W-1:0]      hb_beats,
    input  logic                   hb_ack,
    input  logic                   hb_rvalid,
    input  logic [DATA_W-1:0]      hb_rdata,
    output logic                   hb_wvalid,
    input  logic                   hb_wready,
    output logic [DATA_W-1:0]      hb_wdata,
    output logic                   pm_we,
    output logic [PA_W-1:0]        pm_waddr,
    output logic [DATA_W-1:0]      pm_wdata,
    output logic [PA_W-1:0]        pm_raddr,
    input  logic [DATA_W-1:0]      pm_rdata
);
    localparam int FI_W     = (NFRAG > 1) ? $clog2(NFRAG) : 1;
    localparam int PG_W     = $clog2(PAGE_WORDS);
    localparam int OFF_ADDR = NFRAG * LEN_W;
    localparam int OFF_PKT  = OFF_ADDR + NFRAG * HA_W;
    localparam int OFF_NF   = OFF_PKT + PA_W;
    localparam int OFF_IRQ  = OFF_NF + NF_W;
    localparam int OFF_DIR  = OFF_IRQ + 1;
    localparam int OFF_TAG  = OFF_DIR + 1;
    localparam int ENT_W    = OFF_TAG + TAG_W;

    sg_state_t state, state_nx;

    // ---------------- request queue ----------------
    logic             req_push, req_pop, req_full, req_empty;
    logic [ENT_W-1:0] req_in, head;

    assign req_in   = {req_tag, req_dir, req_irq, req_nfrag, req_pkt_addr,
                       req_frag_addr, req_frag_len};
    assign req_push = req_valid && !req_full;

    sgdma_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_req_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_push), .wr_data(req_in),
        .rd_en(req_pop), .rd_data(head),
        .full(req_full), .empty(req_empty)
    );

    // ---------------- head request fields ----------------
    logic [TAG_W-1:0] hd_tag;
    sg_dir_t          hd_dir;
    logic             hd_irq;
    logic [NF_W-1:0]  hd_nfrag;
    logic [PA_W-1:0]  hd_pkt;
    logic [HA_W-1:0]  fa [NFRAG];
    logic [LEN_W-1:0] fl [NFRAG];
    logic [NFRAG-1:0] frag_bad;
    logic             chk_err;

    assign hd_tag   = head[OFF_TAG +: TAG_W];
    assign hd_dir   = sg_dir_t'(head[OFF_DIR]);
    assign hd_irq   = head[OFF_IRQ];
    assign hd_nfrag = head[OFF_NF +: NF_W];
    assign hd_pkt   = head[OFF_PKT +: PA_W];

    for (genvar g = 0; g < NFRAG; g++) begin : g_frag
        assign fa[g] = head[OFF_ADDR + g*HA_W +: HA_W];
        assign fl[g] = head[g*LEN_W +: LEN_W];
        assign frag_bad[g] = (NF_W'(g) < hd_nfrag) &&
                             ((fl[g] == '0) || (fl[g] > LEN_W'(MAX_FRAG_WORDS)));
    end

    assign chk_err = (hd_nfrag == '0) || (hd_nfrag > NF_W'(NFRAG)) || (|frag_bad);

    // ---------------- working registers ----------------
    logic [FI_W-1:0]   frag_idx, nxt_idx;
    logic [HA_W-1:0]   cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [PA_W-1:0]   pm_ptr;
    logic [BEAT_W-1:0] beats_left, calc_beats;
    logic              err_r;
    logic              beat, last_frag;

    assign nxt_idx   = frag_idx + FI_W'(1);
    assign last_frag = (NF_W'(frag_idx) + NF_W'(1)) == hd_nfrag;
    assign beat      = (state == S_DATA) &&
                       ((hd_dir == DIR_SCATTER) ? hb_wready : hb_rvalid);

    sgdma_burst_calc #(
        .HA_W(HA_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W),
        .MAX_BURST(MAX_BURST), .PAGE_WORDS(PAGE_WORDS)
    ) u_calc (
        .addr(cur_addr), .remain(remain), .beats(calc_beats)
    );

    // ---------------- response queue ----------------
    logic resp_push, resp_full, resp_empty;

    assign resp_push = (state == S_DONE) && !resp_full;
    assign req_pop   = resp_push;

    sgdma_fifo #(.WIDTH(TAG_W + 1), .DEPTH(QDEPTH)) u_resp_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(resp_push), .wr_data({err_r, hd_tag}),
        .rd_en(resp_pop && !resp_empty), .rd_data(resp_data),
        .full(resp_full), .empty(resp_empty)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (!req_empty) state_nx = S_CHECK;
            S_CHECK: state_nx = chk_err ? S_DONE : S_CMD;
            S_CMD:   if (hb_ack) state_nx = S_DATA;
            S_DATA:  if (beat && beats_left == BEAT_W'(1))
                         state_nx = (remain == LEN_W'(1)) ? S_NEXT : S_CMD;
            S_NEXT:  state_nx = last_frag ? S_DONE : S_CMD;
            S_DONE:  if (!resp_full) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frag_idx   <= '0;
            cur_addr   <= '0;
            remain     <= '0;
            pm_ptr     <= '0;
            beats_left <= '0;
            err_r      <= 1'b0;
        end else begin
            unique case (state)
                S_CHECK: begin
                    err_r    <= chk_err;
                    frag_idx <= '0;
                    cur_addr <= fa[0];
                    remain   <= fl[0];
                    pm_ptr   <= hd_pkt;
                end
                S_CMD: if (hb_ack) beats_left <= calc_beats;
                S_DATA: if (beat) begin
                    cur_addr   <= cur_addr + HA_W'(1);
                    pm_ptr     <= pm_ptr + PA_W'(1);
                    remain     <= remain - LEN_W'(1);
                    beats_left <= beats_left - BEAT_W'(1);
                end
                S_NEXT: if (!last_frag) begin
                    frag_idx <= nxt_idx;
                    cur_addr <= fa[nxt_idx];
                    remain   <= fl[nxt_idx];
                end
                default: ;
            endcase
        end
    end

    // ---------------- interrupt ----------------
    logic irq_set;
    assign irq_set = resp_push && hd_irq;

    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (irq_set)  irq <= 1'b1;
        else if (resp_pop) irq <= 1'b0;
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = !req_full;
        q_full     = req_full;
        q_empty    = req_empty;
        resp_valid = !resp_empty;
        hb_req     = (state == S_CMD);
        hb_we      = (hd_dir == DIR_SCATTER);
        hb_addr    = cur_addr;
        hb_beats   = calc_beats;
        hb_wvalid  = (state == S_DATA) && (hd_dir == DIR_SCATTER);
        hb_wdata   = pm_rdata;
        pm_raddr   = pm_ptr;
        pm_we      = (state == S_DATA) && (hd_dir == DIR_GATHER) && hb_rvalid;
        pm_waddr   = pm_ptr;
        pm_wdata   = hb_rdata;
    end

    // ---------------- assertions ----------------
    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_req && !hb_ack) |=> (hb_req && $stable(hb_addr) && $stable(hb_beats) && $stable(hb_we)));

    assert_burst_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hb_req |-> ((32'(hb_addr[PG_W-1:0]) + 32'(hb_beats)) <= 32'(PAGE_WORDS)));

    assert_burst_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hb_req |-> (hb_beats != '0 && hb_beats <= BEAT_W'(MAX_BURST)));

    assert_err_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hb_req |-> !err_r);

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_pop && !irq_set) |=> !irq);

    assert_stall_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && resp_full && !resp_pop) |=> (state == S_DONE));

endmodule

// File: tb/sgdma_engine_tb.sv
module sgdma_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [3:0]  req_tag;
    logic        req_dir, req_irq;
    logic [2:0]  req_nfrag;
    logic [11:0] req_pkt_addr;
    logic [79:0] req_frag_addr;
    logic [47:0] req_frag_len;
    logic        q_full, q_empty, resp_valid, resp_pop, irq;
    logic [4:0]  resp_data;
    logic        hb_req, hb_we, hb_ack, hb_rvalid, hb_wvalid, hb_wready;
    logic [19:0] hb_addr;
    logic [4:0]  hb_beats;
    logic [31:0] hb_rdata, hb_wdata, pm_wdata, pm_rdata;
    logic        pm_we;
    logic [11:0] pm_waddr, pm_raddr;

    always #4 clk = ~clk;

    sgdma_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_dir(req_dir), .req_irq(req_irq), .req_nfrag(req_nfrag),
        .req_pkt_addr(req_pkt_addr), .req_frag_addr(req_frag_addr),
        .req_frag_len(req_frag_len), .q_full(q_full), .q_empty(q_empty),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_pop(resp_pop),
        .irq(irq), .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_beats(hb_beats), .hb_ack(hb_ack), .hb_rvalid(hb_rvalid),
        .hb_rdata(hb_rdata), .hb_wvalid(hb_wvalid), .hb_wready(hb_wready),
        .hb_wdata(hb_wdata), .pm_we(pm_we), .pm_waddr(pm_waddr),
        .pm_wdata(pm_wdata), .pm_raddr(pm_raddr), .pm_rdata(pm_rdata)
    );

    // ---------------- memories ----------------
    logic [31:0] host_mem [16384];
    logic [31:0] pm_mem   [4096];
    logic [31:0] exp_host [16384];
    logic [31:0] exp_pm   [4096];
    bit          host_touch [16384];
    bit          pm_touch   [4096];

    function automatic logic [31:0] host_init(int a);
        return 32'hA000_0000 ^ (32'(a) * 32'h0000_9E37);
    endfunction
    function automatic logic [31:0] pm_init(int a);
        return 32'h5000_0000 + 32'(a);
    endfunction

    always @(posedge clk) if (pm_we) pm_mem[pm_waddr] <= pm_wdata;
    assign pm_rdata = pm_mem[pm_raddr];

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fail   = 0;
    int cmds     = 0;
    int cyc      = 0;
    logic [4:0] exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- host bus model ----------------
    initial begin
        logic [19:0] a;
        int          n;
        logic        we;
        int          k;
        bit          stall;
        hb_ack = 0; hb_rvalid = 0; hb_rdata = '0; hb_wready = 0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && hb_req) begin
                a = hb_addr; n = int'(hb_beats); we = hb_we; cmds++;
                // R5: burst size and page boundary
                check((n >= 1) && (n <= 16) && ((int'(a[9:0]) + n) <= 1024), "R5",
                      {44'(a), 20'(n)}, 64'd0);
                @(negedge clk);
                // R6: command held while unacknowledged
                check(hb_req && hb_addr == a && int'(hb_beats) == n && hb_we == we, "R6",
                      {43'(hb_addr), 20'(hb_beats), hb_req}, {43'(a), 20'(n), 1'b1});
                hb_ack = 1;
                @(negedge clk);
                hb_ack = 0;
                k = 0;
                while (k < n) begin
                    stall = (cyc % 4 == 3);
                    if (!we) begin
                        hb_rvalid = !stall;
                        hb_rdata  = host_mem[a[13:0]];
                        if (!stall) begin a = a + 20'd1; k++; end
                    end else begin
                        hb_wready = !stall;
                        #1;
                        if (hb_wready && hb_wvalid) begin
                            host_mem[a[13:0]] = hb_wdata;
                            a = a + 20'd1; k++;
                        end
                    end
                    @(negedge clk);
                end
                hb_rvalid = 0; hb_wready = 0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic push_req(input logic [3:0] tag, input logic dir, input logic irqf,
                            input int nf, input int pkt,
                            input int a0, input int l0, input int a1, input int l1,
                            input int a2, input int l2, input int a3, input int l3);
        int  aa [4];
        int  ll [4];
        bit  err;
        int  p;
        aa = '{a0, a1, a2, a3};
        ll = '{l0, l1, l2, l3};
        err = (nf == 0) || (nf > 4);
        for (int i = 0; i < 4; i++)
            if (i < nf && (ll[i] == 0 || ll[i] > 1024)) err = 1;
        if (!err) begin
            p = pkt;
            for (int i = 0; i < nf; i++)
                for (int j = 0; j < ll[i]; j++) begin
                    if (!dir) begin
                        exp_pm[p] = host_init(aa[i] + j); pm_touch[p] = 1;
                    end else begin
                        exp_host[aa[i] + j] = pm_init(p); host_touch[aa[i] + j] = 1;
                    end
                    p++;
                end
        end
        exp_q.push_back({err, tag});
        while (!req_ready) @(negedge clk);
        req_tag = tag; req_dir = dir; req_irq = irqf; req_nfrag = 3'(nf);
        req_pkt_addr = 12'(pkt);
        req_frag_addr = {20'(a3), 20'(a2), 20'(a1), 20'(a0)};
        req_frag_len  = {12'(l3), 12'(l2), 12'(l1), 12'(l0)};
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_resp();
        while (!resp_valid) @(negedge clk);
    endtask

    // ---------------- monitor / scoreboard ----------------
    task automatic drain(int n);
        logic [4:0] e;
        for (int k = 0; k < n; k++) begin
            wait_resp();
            if (exp_q.size() == 0) begin
                check(0, "R7", 64'(resp_data), 64'hFF);
            end else begin
                e = exp_q.pop_front();
                check(resp_data == e, "R7", 64'(resp_data), 64'(e));
            end
            resp_pop = 1;
            @(negedge clk);
            resp_pop = 0;
        end
    endtask

    // ---------------- watchdog ----------------
    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int c0;
        for (int i = 0; i < 16384; i++) host_mem[i] = host_init(i);
        for (int i = 0; i < 4096; i++) pm_mem[i] = pm_init(i);
        rst_n = 0; req_valid = 0; resp_pop = 0; req_tag = '0; req_dir = 0;
        req_irq = 0; req_nfrag = '0; req_pkt_addr = '0;
        req_frag_addr = '0; req_frag_len = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(q_empty && !q_full, "R1", {q_empty, q_full}, 2'b10);
        check(!resp_valid && !irq && !hb_req, "R1", {resp_valid, irq, hb_req}, 0);

        // R3 gather: header, page-crossing fragment, multi-burst fragment
        push_req(4'd1, 0, 0, 3, 12'h010, 'h100, 5, 'h3F8, 20, 'h2000, 40, 0, 0);
        wait_resp();
        check(irq == 0, "R9", irq, 0);               // unflagged completion
        drain(1);

        // R4 scatter, flagged
        push_req(4'd2, 1, 1, 2, 12'h800, 'h3000, 7, 'h33FA, 9, 0, 0, 0, 0);
        wait_resp();
        check(irq == 1, "R9", irq, 1);
        drain(1);
        check(irq == 0, "R9", irq, 0);               // cleared by pop

        // R8 error requests issue no bursts
        c0 = cmds;
        push_req(4'd3, 0, 0, 2, 12'h300, 'h100, 4, 'h200, 0, 0, 0, 0, 0);
        wait_resp();
        check(cmds == c0, "R8", cmds, c0);
        drain(1);
        push_req(4'd4, 0, 0, 0, 12'h300, 'h100, 4, 0, 0, 0, 0, 0, 0);
        drain(1);
        push_req(4'd5, 0, 0, 1, 12'h300, 'h100, 1025, 0, 0, 0, 0, 0, 0);
        drain(1);
        push_req(4'd6, 1, 0, 5, 12'h900, 'h3100, 2, 'h3110, 2, 'h3120, 2, 'h3130, 2);
        drain(1);
        check(cmds == c0, "R8", cmds, c0);
        // unused slots with zero length are ignored; exact maximum length is valid
        push_req(4'd7, 0, 0, 1, 12'h060, 'h600, 3, 0, 0, 0, 0, 0, 0);
        drain(1);
        push_req(4'd8, 0, 0, 1, 12'h200, 'h0A00, 1024, 0, 0, 0, 0, 0, 0);
        drain(1);
        check(cmds == c0 + 1 + 64, "R8", cmds, c0 + 65);

        // R2 / R10 backpressure: sixteen requests, no pops
        fork
            for (int i = 0; i < 16; i++)
                push_req(4'(i), 0, (i == 15), 1, 12'h700 + 2*i, 'h500 + 4*i, 2, 0, 0, 0, 0, 0, 0);
        join_none
        repeat (600) @(negedge clk);
        check(q_full == 1, "R2", q_full, 1);
        check(req_ready == 0, "R2", req_ready, 0);
        check(resp_valid == 1, "R10", resp_valid, 1);
        check(irq == 0, "R9", irq, 0);
        drain(16);
        wait fork;
        repeat (5) @(negedge clk);
        check(q_empty == 1, "R2", q_empty, 1);
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);

        // data placement
        for (int i = 0; i < 4096; i++)
            if (pm_touch[i]) check(pm_mem[i] == exp_pm[i], "R3", pm_mem[i], exp_pm[i]);
        for (int i = 0; i < 16384; i++)
            if (host_touch[i]) check(host_mem[i] == exp_host[i], "R4", host_mem[i], exp_host[i]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule